// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves bytes in both directions at once over a serial link that shares one transfer clock. A byte written by the host waits in a transmit holding register. It then moves into a transmit shift register and leaves on the data-out pin, least significant bit first. During the same clock pulses, the bits arriving on the data-in pin build up in a receive shift register. When the eighth bit arrives, that register is copied into a receive holding register that the host reads. Receiving always rides on a transmission: to take in a byte, the host sends one, which may be a dummy byte.

The transfer clock is made in one of two ways. The first is an internal divider fed by one of three prescaled versions of the system clock. In that case the clock is driven out on the clock pin. The second is the clock pin itself, used as an input. A polarity setting picks the idle level of the clock and which edge shifts and which edge samples. Optional handshake lines let a peer hold off transmission (clear-to-send) and signal that the receiver has room (ready-to-send). Two single-cycle interrupt pulses report buffer and shift progress.

Top module: `sync_serial_xcvr`

## Requirements
- R1: A transfer is exactly DATA_W (8) bits on `txd`, least significant bit first, with no framing bits. `txd` changes only on the leading clock edge: the falling edge when `clk_pol`=0, the rising edge when `clk_pol`=1. `txd` is high out of reset.
- R2: `rxd` is sampled on each trailing edge and assembled least significant bit first. After the eighth bit, `rx_data` holds the byte, `rx_full` is set and `rx_irq` pulses for one cycle. `rd_ack` clears `rx_full`.
- R3: With `use_ext_clk`=0, `sclk_oe`=1 and each half period of `sclk_out` lasts (div_m+1)·P system cycles. P is PRE_A (1) for `pre_sel`=0, PRE_B (8) for 1, and PRE_C (32) for 2 or 3. When idle, `sclk_out` sits high for `clk_pol`=0 and low for `clk_pol`=1.
- R4: With `use_ext_clk`=1, `sclk_oe`=0 and the edges are taken from `sclk_in`. A transfer does not start unless `sclk_in` is at the idle level (high for `clk_pol`=0).
- R5: A transfer starts only when `tx_en`=1 and the transmit holding register is full (`tx_empty`=0). With `cts_en`=1, `cts_n` must also be low. Until then no clock edge is produced.
- R6: A received byte is delivered only if `rx_en`=1 when the transfer starts. With `tx_en`=0, nothing moves even if `rx_en`=1. With `rx_en`=0, a transfer leaves `rx_full` and `rx_irq` untouched.
- R7: With `txirq_on_done`=0, `tx_irq` pulses in the cycle the holding register moves into the shift register, which is the cycle `tx_empty` rises. With `txirq_on_done`=1, it pulses when the shift completes, in the same cycle as `rx_irq`.
- R8: A byte written during a shift loads right after the current byte ends. Every clock half period stays (div_m+1)·P, with no extra gap between bytes.
- R9: `rts_n` is low when `rts_en`=1, `rx_en`=1 and `rx_full`=0. It is high when `rts_en`=1 and either the receiver is off or the receive buffer is full. It is held low when `rts_en`=0.
- R10: `clk_pol`=1 inverts both edges: data changes on rising edges and is sampled on falling edges, and the clock idles low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| use_ext_clk | input | 1 | 1: transfer clock from `sclk_in`; 0: internal divider |
| clk_pol | input | 1 | Clock polarity / edge select |
| pre_sel | input | 2 | Prescaler choice for the internal divider |
| div_m | input | DIV_W | Divider value m |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| cts_en | input | 1 | Clear-to-send gating enable |
| rts_en | input | 1 | Ready-to-send output enable |
| txirq_on_done | input | 1 | Transmit interrupt point select |
| wr_valid | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | DATA_W | Byte to transmit |
| rd_ack | input | 1 | Host has read `rx_data` |
| rx_data | output | DATA_W | Receive holding register |
| tx_empty | output | 1 | Transmit holding register empty |
| rx_full | output | 1 | Receive holding register full |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |
| sclk_in | input | 1 | Clock pin input |
| sclk_out | output | 1 | Clock pin output value |
| sclk_oe | output | 1 | Clock pin output enable |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Ready-to-send, active low |

## Verification
The hardest case to reach is the seam between two bytes. The second byte must be written while the first is still shifting, and the first clock edge of the new byte must come exactly one half period after the last edge of the old one. The bench writes the second byte as soon as `tx_empty` rises and then times every clock edge across both bytes. A peer model on the pins answers each leading edge with a data bit and records `txd` on each trailing edge. A second hard case is the external-clock start gate. The bench parks `sclk_in` at the wrong level with data waiting, confirms that nothing starts, and then hand-toggles the pin.

// File: rtl/sxc_pkg.sv
package sxc_pkg;
   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_SHIFT = 1'b1
   } sxc_state_t;

   typedef struct packed {
      logic lead;
      logic trail;
   } sxc_edge_t;
endpackage

// File: rtl/sxc_clkgen.sv
module sxc_clkgen
   import sxc_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int PRE_A       = 1,
   parameter int PRE_B       = 8,
   parameter int PRE_C       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             pol,
   input  logic             ext_sel,
   input  logic [1:0]       pre_sel,
   input  logic [DIV_W-1:0] div_m,
   input  logic             sclk_in,
   output sxc_edge_t        edge_o,
   output logic             sclk_out,
   output logic             pin_level
);
   localparam int PRE_MAX = (PRE_A > PRE_B) ? ((PRE_A > PRE_C) ? PRE_A : PRE_C)
                                            : ((PRE_B > PRE_C) ? PRE_B : PRE_C);
   localparam int PRE_W   = (PRE_MAX < 2) ? 1 : $clog2(PRE_MAX);

   if (PRE_A < 1 || PRE_B < 1 || PRE_C < 1) begin : g_bad_pre
      $error("sxc_clkgen: prescale factors must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sxc_clkgen: SYNC_STAGES must be at least 2");
   end

   // ---------------- prescaler and half-period divider ----------------
   logic [PRE_W-1:0] pre_lim, pre_cnt;
   logic [DIV_W-1:0] div_cnt;
   logic             tick, toggle, idle_lvl, sclk_q;

   always_comb begin
      unique case (pre_sel)
         2'd0:    pre_lim = PRE_W'(PRE_A - 1);
         2'd1:    pre_lim = PRE_W'(PRE_B - 1);
         default: pre_lim = PRE_W'(PRE_C - 1);
      endcase
   end

   assign idle_lvl = ~pol;
   assign tick     = (pre_cnt == pre_lim);
   assign toggle   = run && !ext_sel && tick && (div_cnt == div_m);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
         div_cnt <= '0;
         sclk_q  <= 1'b1;
      end else if (!run || ext_sel) begin
         pre_cnt <= '0;
         div_cnt <= '0;
         sclk_q  <= idle_lvl;
      end else begin
         pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
         if (tick) div_cnt <= (div_cnt == div_m) ? '0 : div_cnt + 1'b1;
         if (toggle) sclk_q <= ~sclk_q;
      end
   end

   assign sclk_out = sclk_q;

   // ---------------- external pin synchroniser ----------------
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   pin_prev;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[s] <= 1'b0;
         else        sync_q[s] <= (s == 0) ? sclk_in : sync_q[(s == 0) ? 0 : s-1];
      end
   end

   assign pin_level = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_prev <= 1'b0;
      else        pin_prev <= pin_level;
   end

   logic pin_rise, pin_fall, ext_lead, ext_trail;
   assign pin_rise  = pin_level & ~pin_prev;
   assign pin_fall  = ~pin_level & pin_prev;
   assign ext_lead  = pol ? pin_rise : pin_fall;
   assign ext_trail = pol ? pin_fall : pin_rise;

   always_comb begin
      if (ext_sel) begin
         edge_o.lead  = run && ext_lead;
         edge_o.trail = run && ext_trail;
      end else begin
         edge_o.lead  = toggle && (sclk_q == idle_lvl);
         edge_o.trail = toggle && (sclk_q != idle_lvl);
      end
   end

   // R3: the clock rests at its idle level whenever no transfer runs
   a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ext_sel) |=> (sclk_out == !$past(pol)));

   // R1: one edge kind per cycle
   a_r1_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !(edge_o.lead && edge_o.trail));
endmodule

// File: rtl/sxc_engine.sv
module sxc_engine
   import sxc_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              rx_en,
   input  logic              txirq_on_done,
   input  logic              start_gate,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_ack,
   input  sxc_edge_t         edge_i,
   input  logic              rxd,
   output logic              busy,
   output logic              txd,
   output logic [DATA_W-1:0] rx_data,
   output logic              tx_empty,
   output logic              rx_full,
   output logic              tx_irq,
   output logic              rx_irq
);
   localparam int CNT_W = $clog2(DATA_W + 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("sxc_engine: DATA_W must be at least 2");
   end

   sxc_state_t        state;
   logic [DATA_W-1:0] tx_buf, tx_sh, rx_sh, rx_next;
   logic [CNT_W-1:0]  bit_cnt;
   logic              rx_arm, start_ok, last_bit;

   assign start_ok = tx_en && !tx_empty && start_gate;
   assign rx_next  = {rxd, rx_sh[DATA_W-1:1]};
   assign last_bit = edge_i.trail && (bit_cnt == CNT_W'(DATA_W - 1));
   assign busy     = (state == ST_SHIFT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         tx_buf   <= '0;
         tx_sh    <= '0;
         rx_sh    <= '0;
         rx_data  <= '0;
         bit_cnt  <= '0;
         rx_arm   <= 1'b0;
         tx_empty <= 1'b1;
         rx_full  <= 1'b0;
         tx_irq   <= 1'b0;
         rx_irq   <= 1'b0;
         txd      <= 1'b1;
      end else begin
         tx_irq <= 1'b0;
         rx_irq <= 1'b0;
         if (rd_ack) rx_full <= 1'b0;

         unique case (state)
            ST_IDLE: begin
               if (start_ok) begin
                  tx_sh    <= tx_buf;
                  tx_empty <= 1'b1;
                  rx_arm   <= rx_en;
                  bit_cnt  <= '0;
                  state    <= ST_SHIFT;
                  tx_irq   <= !txirq_on_done;
               end
            end
            ST_SHIFT: begin
               if (edge_i.lead) begin
                  txd   <= tx_sh[0];
                  tx_sh <= tx_sh >> 1;
               end
               if (edge_i.trail) begin
                  rx_sh   <= rx_next;
                  bit_cnt <= bit_cnt + 1'b1;
               end
               if (last_bit) begin
                  if (rx_arm) begin
                     rx_data <= rx_next;
                     rx_full <= 1'b1;
                     rx_irq  <= 1'b1;
                  end
                  if (start_ok) begin
                     tx_sh    <= tx_buf;
                     tx_empty <= 1'b1;
                     rx_arm   <= rx_en;
                     bit_cnt  <= '0;
                     tx_irq   <= 1'b1;
                  end else begin
                     state  <= ST_IDLE;
                     tx_irq <= txirq_on_done;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase

         if (wr_valid) begin
            tx_buf   <= wr_data;
            tx_empty <= 1'b0;
         end
      end
   end

   // R1: bit counter stays inside one byte while shifting
   a_r1_bit_range: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (bit_cnt < CNT_W'(DATA_W)));

   // R5: leaving idle needs transmit enabled and data held
   a_r5_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |=> ((state == ST_IDLE) || $past(tx_en && !tx_empty)));

   // R2: a receive pulse always leaves a full buffer behind
   a_r2_irq_full: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> rx_full);
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
   import sxc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV_W       = 8,
   parameter int PRE_A       = 1,
   parameter int PRE_B       = 8,
   parameter int PRE_C       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              use_ext_clk,
   input  logic              clk_pol,
   input  logic [1:0]        pre_sel,
   input  logic [DIV_W-1:0]  div_m,
   input  logic              tx_en,
   input  logic              rx_en,
   input  logic              cts_en,
   input  logic              rts_en,
   input  logic              txirq_on_done,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_ack,
   output logic [DATA_W-1:0] rx_data,
   output logic              tx_empty,
   output logic              rx_full,
   output logic              tx_irq,
   output logic              rx_irq,
   input  logic              sclk_in,
   output logic              sclk_out,
   output logic              sclk_oe,
   output logic              txd,
   input  logic              rxd,
   input  logic              cts_n,
   output logic              rts_n
);
   sxc_edge_t edges;
   logic      busy, pin_level, start_gate, clk_ready, cts_ready;

   assign cts_ready  = !cts_en || !cts_n;
   assign clk_ready  = !use_ext_clk || (pin_level == !clk_pol);
   assign start_gate = cts_ready && clk_ready;
   assign sclk_oe    = !use_ext_clk;
   assign rts_n      = rts_en ? !(rx_en && !rx_full) : 1'b0;

   sxc_clkgen #(
      .DIV_W(DIV_W), .PRE_A(PRE_A), .PRE_B(PRE_B), .PRE_C(PRE_C),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_clkgen (
      .clk(clk), .rst_n(rst_n), .run(busy), .pol(clk_pol),
      .ext_sel(use_ext_clk), .pre_sel(pre_sel), .div_m(div_m),
      .sclk_in(sclk_in), .edge_o(edges), .sclk_out(sclk_out),
      .pin_level(pin_level)
   );

   sxc_engine #(.DATA_W(DATA_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
      .txirq_on_done(txirq_on_done), .start_gate(start_gate),
      .wr_valid(wr_valid), .wr_data(wr_data), .rd_ack(rd_ack),
      .edge_i(edges), .rxd(rxd), .busy(busy), .txd(txd),
      .rx_data(rx_data), .tx_empty(tx_empty), .rx_full(rx_full),
      .tx_irq(tx_irq), .rx_irq(rx_irq)
   );

   // R7: transmit pulse on completion coincides with the receive pulse
   a_r7_done_point: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_irq && txirq_on_done && rx_en) |-> (rx_irq || tx_empty));
endmodule

// File: tb/sim_sync_serial_xcvr.sv
`timescale 1ns/1ps
module sim_sync_serial_xcvr;
   logic       clk = 1'b0, rst_n = 1'b0;
   logic       use_ext_clk = 0, clk_pol = 0, tx_en = 1, rx_en = 1;
   logic       cts_en = 0, rts_en = 1, txirq_on_done = 0;
   logic [1:0] pre_sel = 0;
   logic [7:0] div_m = 0, wr_data = 0, rx_data;
   logic       wr_valid = 0, rd_ack = 0, sclk_in_d = 1, rxd_d = 0, cts_n = 1;
   logic       tx_empty, rx_full, tx_irq, rx_irq, sclk_out, sclk_oe, txd, rts_n;

   always #2 clk = ~clk;

   sync_serial_xcvr u0 (
      .clk(clk), .rst_n(rst_n), .use_ext_clk(use_ext_clk), .clk_pol(clk_pol),
      .pre_sel(pre_sel), .div_m(div_m), .tx_en(tx_en), .rx_en(rx_en),
      .cts_en(cts_en), .rts_en(rts_en), .txirq_on_done(txirq_on_done),
      .wr_valid(wr_valid), .wr_data(wr_data), .rd_ack(rd_ack),
      .rx_data(rx_data), .tx_empty(tx_empty), .rx_full(rx_full),
      .tx_irq(tx_irq), .rx_irq(rx_irq), .sclk_in(sclk_in_d),
      .sclk_out(sclk_out), .sclk_oe(sclk_oe), .txd(txd), .rxd(rxd_d),
      .cts_n(cts_n), .rts_n(rts_n)
   );

   int checks = 0, fails = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // peer model on the pins
   logic [15:0] cap, sl_pat = 16'h0;
   int cap_n, sl_idx, edges, gmin, gmax, last_cyc;
   int txirq_n, txirq_rise, txirq_rx, rxirq_n;
   logic prev_pin = 1'b1, prev_empty = 1'b1, pin;

   always @(negedge clk) begin
      pin = sclk_oe ? sclk_out : sclk_in_d;
      if (rst_n && pin != prev_pin) begin
         edges++;
         if (edges > 1) begin
            if (cyc - last_cyc < gmin) gmin = cyc - last_cyc;
            if (cyc - last_cyc > gmax) gmax = cyc - last_cyc;
         end
         last_cyc = cyc;
         if (pin == clk_pol) rxd_d = sl_pat[sl_idx % 16];
         else begin cap = {txd, cap[15:1]}; cap_n++; sl_idx++; end
      end
      prev_pin = pin;
      if (tx_irq) begin
         txirq_n++;
         if (tx_empty && !prev_empty) txirq_rise++;
         if (rx_irq) txirq_rx++;
      end
      if (rx_irq) rxirq_n++;
      prev_empty = tx_empty;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_mon();
      @(posedge clk); #1;
      cap = 0; cap_n = 0; sl_idx = 0; edges = 0; gmin = 1 << 30; gmax = 0;
      txirq_n = 0; txirq_rise = 0; txirq_rx = 0; rxirq_n = 0;
   endtask

   task automatic write_byte(input logic [7:0] d);
      @(negedge clk); wr_data = d; wr_valid = 1;
      @(negedge clk); wr_valid = 0;
   endtask

   task automatic ack_rx();
      @(negedge clk); rd_ack = 1;
      @(negedge clk); rd_ack = 0;
   endtask

   task automatic wait_rx(input int target);
      for (int i = 0; i < 4000 && rxirq_n < target; i++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic wait_cap(input int target);
      for (int i = 0; i < 4000 && cap_n < target; i++) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(tx_empty == 1 && rx_full == 0, "R2 reset buffers", {tx_empty, rx_full}, 2'b10);
      chk(txd == 1, "R1 reset txd", txd, 1);
      chk(sclk_out == 1 && sclk_oe == 1, "R3 reset idle clock", {sclk_out, sclk_oe}, 2'b11);
      chk(rts_n == 0, "R9 rts ready", rts_n, 0);
   endtask

   task automatic t_basic();
      clear_mon(); sl_pat = 16'h00C5;
      write_byte(8'h3A);
      wait_rx(1);
      chk(cap[15:8] == 8'h3A, "R1 txd byte lsb first", cap[15:8], 8'h3A);
      chk(rx_data == 8'hC5 && rx_full, "R2 rx byte", rx_data, 8'hC5);
      chk(rts_n == 1, "R9 rts full", rts_n, 1);
      chk(gmin == 1 && gmax == 1, "R3 half period m0 p1", gmax, 1);
      ack_rx();
      chk(rx_full == 0 && rts_n == 0, "R2 rd_ack clears", {rx_full, rts_n}, 0);
      chk(txirq_n == 1 && txirq_rise == 1, "R7 irq at load", txirq_rise, 1);
   endtask

   task automatic t_rate(input logic [1:0] ps, input logic [7:0] m, input int half);
      @(negedge clk); pre_sel = ps; div_m = m;
      clear_mon(); sl_pat = 16'h0011;
      write_byte(8'h96);
      wait_rx(1);
      chk(gmin == half && gmax == half, "R3 half period", gmax, half);
      chk(cap[15:8] == 8'h96, "R3 data at slow rate", cap[15:8], 8'h96);
      ack_rx();
      @(negedge clk); pre_sel = 0; div_m = 0;
   endtask

   task automatic t_pol1();
      @(negedge clk); clk_pol = 1;
      repeat (3) @(negedge clk);
      chk(sclk_out == 0, "R10 idle low", sclk_out, 0);
      clear_mon(); sl_pat = 16'h005E;
      @(negedge clk); div_m = 1;
      write_byte(8'hE1);
      wait_rx(1);
      chk(cap[15:8] == 8'hE1, "R10 txd pol1", cap[15:8], 8'hE1);
      chk(rx_data == 8'h5E, "R10 rxd pol1", rx_data, 8'h5E);
      ack_rx();
      @(negedge clk); clk_pol = 0; div_m = 0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_cts();
      @(negedge clk); cts_en = 1; cts_n = 1;
      clear_mon(); sl_pat = 16'h0077;
      write_byte(8'h42);
      repeat (40) @(negedge clk);
      chk(tx_empty == 0 && edges == 0, "R5 held by cts", edges, 0);
      @(negedge clk); cts_n = 0;
      wait_rx(1);
      chk(cap[15:8] == 8'h42 && tx_empty, "R5 sent after cts", cap[15:8], 8'h42);
      ack_rx();
      @(negedge clk); cts_en = 0; cts_n = 1;
   endtask

   task automatic t_rx_gate();
      @(negedge clk); tx_en = 0; rx_en = 1;
      clear_mon(); sl_pat = 16'h00AA;
      write_byte(8'h19);
      repeat (40) @(negedge clk);
      chk(tx_empty == 0 && rx_full == 0 && edges == 0, "R6 no rx without tx", edges, 0);
      @(negedge clk); tx_en = 1; rx_en = 0;
      wait_cap(8);
      chk(cap[15:8] == 8'h19, "R6 tx alone", cap[15:8], 8'h19);
      chk(rx_full == 0 && rxirq_n == 0, "R6 rx off untouched", rxirq_n, 0);
      chk(rts_n == 1, "R9 rts rx off", rts_n, 1);
      @(negedge clk); rx_en = 1;
   endtask

   task automatic t_done_irq();
      @(negedge clk); txirq_on_done = 1;
      clear_mon(); sl_pat = 16'h0033;
      write_byte(8'h5C);
      wait_rx(1);
      chk(txirq_n == 1 && txirq_rx == 1, "R7 irq at completion", txirq_rx, 1);
      ack_rx();
      @(negedge clk); txirq_on_done = 0;
   endtask

   task automatic t_b2b();
      @(negedge clk); div_m = 2;
      clear_mon(); sl_pat = 16'h9D4B;
      write_byte(8'hA7);
      for (int i = 0; i < 200 && !tx_empty; i++) @(negedge clk);
      write_byte(8'h2E);
      wait_rx(2);
      chk(cap_n == 16 && cap == 16'h2EA7, "R8 both bytes", cap, 16'h2EA7);
      chk(gmin == 3 && gmax == 3, "R8 no gap", gmax, 3);
      chk(rx_data == 8'h9D && rxirq_n == 2, "R8 second rx byte", rx_data, 8'h9D);
      chk(txirq_rise == 2, "R7 irq at reload", txirq_rise, 2);
      ack_rx();
      @(negedge clk); div_m = 0;
   endtask

   task automatic t_ext();
      @(negedge clk); use_ext_clk = 1; sclk_in_d = 0;
      repeat (6) @(negedge clk);
      clear_mon(); sl_pat = 16'h00D2;
      write_byte(8'h6B);
      repeat (30) @(negedge clk);
      chk(tx_empty == 0 && sclk_oe == 0, "R4 wrong idle level holds", tx_empty, 0);
      @(negedge clk); sclk_in_d = 1;
      repeat (8) @(negedge clk);
      chk(tx_empty == 1, "R4 start at idle level", tx_empty, 1);
      clear_mon();
      for (int h = 0; h < 16; h++) begin
         repeat (6) @(negedge clk);
         sclk_in_d = ~sclk_in_d;
      end
      repeat (10) @(negedge clk);
      chk(cap[15:8] == 8'h6B, "R4 ext txd", cap[15:8], 8'h6B);
      chk(rx_data == 8'hD2 && rx_full, "R4 ext rx", rx_data, 8'hD2);
      ack_rx();
      @(negedge clk); use_ext_clk = 0;
   endtask

   bit done = 0;
   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1;
      repeat (3) @(negedge clk);
      t_reset();
      t_basic();
      t_rate(2'd1, 8'd2, 24);
      t_rate(2'd2, 8'd0, 32);
      t_pol1();
      t_cts();
      t_rx_gate();
      t_done_irq();
      t_b2b();
      t_ext();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule